// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Request Routing

This block compares two divided pulse trains, one taken from the reference divider and one from the RF feedback divider, and converts their relative timing into up and down requests for two charge-pump channels. The detector is a pair of edge-set flags. The flag of whichever input rises first is set, and both flags are cleared together one cycle after the second edge arrives. Because that clear happens a cycle late, both requests overlap briefly on every comparison, so small phase errors still produce a response and there is no dead band. The phase error can therefore span a full cycle of the comparison rate. If one input rises repeatedly before the other rises at all, its flag stays set, so the detector also pulls in frequency.

Configuration comes from two stored words. The active frequency word supplies a sense bit and a two-bit gain field. The reference word supplies a monitor-enable bit and a lock-gate bit. The sense bit reverses the loop polarity: it swaps which input drives the up flag and swaps the two monitor outputs. The monitor-enable bit passes the raw divider pulses to the two monitor outputs. The lock-gate bit lets a digital lock indication turn off pump 1. When the lock-gate bit is clear, the monitor-enable bit turns pump 1 off instead. The lock indication is asynchronous and passes through a synchroniser. The gain field is decoded into a pump 1 current code and a pump 2 multiplier expressed in half-units.

Top module: `pdcp_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all four pump request outputs are low.
- R2: With `sense`=0, a rising edge on `ref_pulse` sets the up request at the next clock edge. The up request stays high until `rf_pulse` rises. The down request is then set, both requests are high for one cycle, and both drop together at the following edge. The mirror case, where `rf_pulse` leads, sets the down request first.
- R3: When `ref_pulse` and `rf_pulse` rise on the same clock edge, up and down are both high for exactly one cycle.
- R4: With `sense`=1, the detector inputs are swapped, so a leading `rf_pulse` edge sets the up request and a leading `ref_pulse` edge sets the down request.
- R5: With `mon_en`=1 and `sense`=0, `mon_a` follows `rf_pulse` and `mon_b` follows `ref_pulse` combinationally. With `sense`=1, the two assignments are exchanged. With `mon_en`=0, both monitor outputs are low.
- R6: `cp1_code` equals {gain[1],gain[0]}, where 0,1,2,3 mean 50, 75, 125 and 200 µA. `cp2_mult_x2` is 2, 3, 5 or 8 for those codes, which means ×1, ×1.5, ×2.5 and ×4.
- R7: With `lock_gate`=0, pump 1 follows the detector when `mon_en`=0 and is held off, with both pump 1 requests low, when `mon_en`=1.
- R8: With `lock_gate`=1, pump 1 is held off while the synchronised lock is high and follows the detector otherwise. Lock passes through SYNC_STAGES flip-flops. The default of 2 means the value of `lock_in` sampled at clock edge k takes effect after edge k+1.
- R9: The pump 2 requests always follow the detector, whatever the settings of `mon_en`, `lock_gate` and the lock input.
- R10: A second leading edge that arrives before the lagging edge leaves the leading request high without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Divided reference pulse (synchronous) |
| rf_pulse | input | 1 | Divided RF feedback pulse (synchronous) |
| sense | input | 1 | Polarity bit from the active frequency word |
| gain | input | 2 | Gain field {G2,G1} from the active frequency word |
| mon_en | input | 1 | Reference-word bit: monitor outputs on |
| lock_gate | input | 1 | Reference-word bit: lock disables pump 1 |
| lock_in | input | 1 | Asynchronous lock indication, active high |
| p1_up | output | 1 | Pump 1 source request |
| p1_dn | output | 1 | Pump 1 sink request |
| p2_up | output | 1 | Pump 2 source request |
| p2_dn | output | 1 | Pump 2 sink request |
| mon_a | output | 1 | First monitor output |
| mon_b | output | 1 | Second monitor output |
| cp1_code | output | 2 | Pump 1 current code |
| cp2_mult_x2 | output | 4 | Pump 2 multiplier times two |

## Verification
The bench builds the block with its default two-stage lock synchroniser. With that depth, the latency from a change on `lock_in` to pump 1 turning off or on is short enough to observe inside a single comparison period, so it can be checked against an explicit queue model. The bench sweeps all four gain codes and both polarities. It covers leading, lagging and coincident edges, a double leading edge, and all four combinations of the monitor-enable and lock-gate bits. The lock input is toggled between comparison pairs.

// File: rtl/pdcp_pkg.sv
package pdcp_pkg;

    localparam int GAIN_W = 2;
    localparam int MULT_W = 4;

    typedef struct packed {
        logic              sense;
        logic [GAIN_W-1:0] gain;
    } fword_t;

    typedef struct packed {
        logic mon_en;
        logic lock_gate;
    } rword_t;

    typedef struct packed {
        logic up;
        logic dn;
    } req_t;

    typedef enum logic [1:0] {
        CP1_50  = 2'd0,
        CP1_75  = 2'd1,
        CP1_125 = 2'd2,
        CP1_200 = 2'd3
    } cp1_code_e;

    // pump 2 multiplier in half-units
    function automatic logic [MULT_W-1:0] mult_half(input logic [GAIN_W-1:0] g);
        case (g)
            2'd0:    return MULT_W'(2);
            2'd1:    return MULT_W'(3);
            2'd2:    return MULT_W'(5);
            default: return MULT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/pdcp_sync.sv
module pdcp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pdcp_pfd.sv
module pdcp_pfd
    import pdcp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lead_in,
    input  logic lag_in,
    output req_t req
);
    logic lead_d, lag_d;
    req_t st;
    logic lead_rise, lag_rise, both;

    assign lead_rise = lead_in & ~lead_d;
    assign lag_rise  = lag_in & ~lag_d;
    assign both      = st.up & st.dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_d <= 1'b0;
            lag_d  <= 1'b0;
            st     <= '0;
        end else begin
            lead_d <= lead_in;
            lag_d  <= lag_in;
            st.up  <= (st.up & ~both) | lead_rise;
            st.dn  <= (st.dn & ~both) | lag_rise;
        end
    end

    assign req = st;
endmodule

// File: rtl/pdcp_route.sv
module pdcp_route
    import pdcp_pkg::*;
(
    input  fword_t fw,
    input  rword_t rw,
    input  logic   lock_s,
    input  logic   ref_i,
    input  logic   rf_i,
    input  req_t   req,
    output req_t   p1,
    output req_t   p2,
    output logic   mon_a,
    output logic   mon_b,
    output logic [GAIN_W-1:0] cp1_code,
    output logic [MULT_W-1:0] cp2_mult
);
    logic p1_on;

    always_comb begin
        if (rw.lock_gate) p1_on = ~lock_s;
        else              p1_on = ~rw.mon_en;
        p1.up = req.up & p1_on;
        p1.dn = req.dn & p1_on;
        p2    = req;
        mon_a = rw.mon_en & (fw.sense ? ref_i : rf_i);
        mon_b = rw.mon_en & (fw.sense ? rf_i : ref_i);
        cp1_code = GAIN_W'(cp1_code_e'(fw.gain));
        cp2_mult = mult_half(fw.gain);
    end
endmodule

// File: rtl/pdcp_ctrl.sv
module pdcp_ctrl
    import pdcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_pulse,
    input  logic              rf_pulse,
    input  logic              sense,
    input  logic [1:0]        gain,
    input  logic              mon_en,
    input  logic              lock_gate,
    input  logic              lock_in,
    output logic              p1_up,
    output logic              p1_dn,
    output logic              p2_up,
    output logic              p2_dn,
    output logic              mon_a,
    output logic              mon_b,
    output logic [1:0]        cp1_code,
    output logic [3:0]        cp2_mult_x2
);
    fword_t fw;
    rword_t rw;
    req_t   req, p1, p2;
    logic   lock_s, lead, lag;

    assign fw   = '{sense: sense, gain: gain};
    assign rw   = '{mon_en: mon_en, lock_gate: lock_gate};
    assign lead = sense ? rf_pulse : ref_pulse;
    assign lag  = sense ? ref_pulse : rf_pulse;

    pdcp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(lock_in), .q(lock_s)
    );

    pdcp_pfd u_pfd (
        .clk(clk), .rst(rst), .lead_in(lead), .lag_in(lag), .req(req)
    );

    pdcp_route u_route (
        .fw(fw), .rw(rw), .lock_s(lock_s), .ref_i(ref_pulse), .rf_i(rf_pulse),
        .req(req), .p1(p1), .p2(p2), .mon_a(mon_a), .mon_b(mon_b),
        .cp1_code(cp1_code), .cp2_mult(cp2_mult_x2)
    );

    assign p1_up = p1.up;
    assign p1_dn = p1.dn;
    assign p2_up = p2.up;
    assign p2_dn = p2.dn;
endmodule

// File: rtl/pdcp_ctrl_chk.sv
module pdcp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_pulse,
    input logic       rf_pulse,
    input logic       sense,
    input logic [1:0] gain,
    input logic       mon_en,
    input logic       lock_gate,
    input logic       lock_in,
    input logic       p1_up,
    input logic       p1_dn,
    input logic       p2_up,
    input logic       p2_dn,
    input logic       mon_a,
    input logic       mon_b,
    input logic [1:0] cp1_code,
    input logic [3:0] cp2_mult_x2
);
    logic [1:0] since;

    always_ff @(posedge clk) begin
        if (rst)            since <= 2'd0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    // R3: overlap of up and down lasts one cycle unless a fresh edge arrives
    a_r3_overlap_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (p2_up && p2_dn) |=> (!(p2_up && p2_dn) || $rose(ref_pulse) || $rose(rf_pulse) || !$stable(sense)));

    // R5
    a_r5_mon_off: assert property (@(posedge clk) disable iff (rst)
        !mon_en |-> (!mon_a && !mon_b));

    // R6
    a_r6_top_gain: assert property (@(posedge clk) disable iff (rst)
        (cp1_code == 2'd3) |-> (cp2_mult_x2 == 4'd8));

    // R7
    a_r7_pump1_off: assert property (@(posedge clk) disable iff (rst)
        (!lock_gate && mon_en) |-> (!p1_up && !p1_dn));

    // R8
    a_r8_lock_off: assert property (@(posedge clk) disable iff (rst)
        (lock_gate && since == 2'd3 && $past(lock_in, 2)) |-> (!p1_up && !p1_dn));

    // R9: pump 1 never requests what pump 2 does not
    a_r9_p1_within_p2: assert property (@(posedge clk) disable iff (rst)
        (p1_up |-> p2_up) and (p1_dn |-> p2_dn));

endmodule

bind pdcp_ctrl pdcp_ctrl_chk u_chk (.*);

// File: tb/tb_pdcp_ctrl.sv
`timescale 1ns/1ps
module tb_pdcp_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 0, rf_pulse = 0, sense = 0, mon_en = 0, lock_gate = 0, lock_in = 0;
    logic [1:0] gain = 2'd0;
    logic p1_up, p1_dn, p2_up, p2_dn, mon_a, mon_b;
    logic [1:0] cp1_code;
    logic [3:0] cp2_mult_x2;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    pdcp_ctrl dut (.*);

    // behavioural reference
    bit m_up, m_dn, prev_a, prev_b;
    bit lq[$];

    always @(posedge clk) begin
        bit a, b, ra, rb, clr;
        if (rst) begin
            m_up = 0; m_dn = 0; prev_a = 0; prev_b = 0;
            lq = {};
            lq.push_back(0); lq.push_back(0);
        end else begin
            a  = sense ? rf_pulse : ref_pulse;
            b  = sense ? ref_pulse : rf_pulse;
            ra = a && !prev_a;
            rb = b && !prev_b;
            clr = m_up && m_dn;
            m_up = (m_up && !clr) || ra;
            m_dn = (m_dn && !clr) || rb;
            prev_a = a; prev_b = b;
            lq.push_back(lock_in);
            void'(lq.pop_front());
        end
    end

    task automatic chk(string req, string nm, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
        end
    endtask

    function automatic int mult_exp(int g);
        int v = 2;
        if (g == 1) v = 3;
        else if (g == 2) v = 5;
        else if (g == 3) v = 8;
        return v;
    endfunction

    task automatic compare_all();
        bit on1, ma, mb;
        if (lock_gate) on1 = !lq[0];
        else           on1 = !mon_en;
        ma = mon_en && (sense ? ref_pulse : rf_pulse);
        mb = mon_en && (sense ? rf_pulse : ref_pulse);
        chk({tag, "/R9"}, "p2_up", p2_up, m_up);
        chk({tag, "/R9"}, "p2_dn", p2_dn, m_dn);
        chk(tag, "p1_up", p1_up, m_up && on1);
        chk(tag, "p1_dn", p1_dn, m_dn && on1);
        chk("R5", "mon_a", mon_a, ma);
        chk("R5", "mon_b", mon_b, mb);
        chk("R6", "cp1_code", cp1_code, gain);
        chk("R6", "cp2_mult_x2", cp2_mult_x2, mult_exp(gain));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    // pulses of two cycles starting at offsets r0 and f0 within a window
    task automatic pair(int r0, int f0, int len);
        for (int t = 0; t < len; t++) begin
            ref_pulse = (t >= r0 && t < r0 + 2);
            rf_pulse  = (t >= f0 && t < f0 + 2);
            tick();
        end
        ref_pulse = 0; rf_pulse = 0;
    endtask

    task automatic pair_set();
        pair(1, 4, 9);   // ref leads
        pair(5, 2, 10);  // rf leads
        pair(2, 2, 6);   // coincident
    endtask

    initial begin
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R1", "p1_up in reset", p1_up, 0);
            chk("R1", "p2_dn in reset", p2_dn, 0);
        end
        rst = 0;
        tick();
        chk("R1", "p2_up after reset", p2_up, 0);
        chk("R1", "p1_dn after reset", p1_dn, 0);

        tag = "R2";
        pair(1, 4, 9);
        pair(6, 2, 11);
        tag = "R3";
        pair(2, 2, 6);
        // directed: coincident edges give exactly one overlap cycle
        ref_pulse = 1; rf_pulse = 1; tick();
        chk("R3", "up on coincidence", p2_up, 1);
        chk("R3", "dn on coincidence", p2_dn, 1);
        tick();
        chk("R3", "up cleared", p2_up, 0);
        chk("R3", "dn cleared", p2_dn, 0);
        ref_pulse = 0; rf_pulse = 0; tick(); tick();

        tag = "R4";
        sense = 1; tick(); tick();
        pair_set();
        ref_pulse = 1; tick();
        chk("R4", "dn from leading ref", p2_dn, 1);
        chk("R4", "up idle", p2_up, 0);
        rf_pulse = 1; tick(); tick();
        ref_pulse = 0; rf_pulse = 0; tick(); tick();

        tag = "R5";
        for (int s = 0; s < 2; s++) begin
            sense = s[0]; mon_en = 1; tick();
            pair_set();
        end

        tag = "R7";
        sense = 0; lock_gate = 0;
        for (int m = 0; m < 2; m++) begin
            mon_en = m[0]; tick();
            pair_set();
        end

        tag = "R8";
        lock_gate = 1;
        for (int m = 0; m < 2; m++) begin
            mon_en = m[0];
            lock_in = 1; pair(3, 6, 10);
            lock_in = 0; pair(1, 5, 10);
            pair(1, 4, 4); lock_in = 1; pair(0, 3, 8);
            lock_in = 0; tick();
        end

        tag = "R6";
        lock_gate = 0; mon_en = 0;
        for (int g = 0; g < 4; g++) begin
            gain = g[1:0]; tick();
            pair(1, 3, 7);
        end

        tag = "R10";
        pair(0, 9, 4);
        ref_pulse = 1; tick();
        chk("R10", "up held on second lead", p2_up, 1);
        ref_pulse = 0; tick(); tick();
        rf_pulse = 1; tick(); tick();
        rf_pulse = 0; tick(); tick();
        chk("R10", "idle after pair", p2_up, 0);

        sense = 1; pair(1, 7, 4); pair(0, 1, 8);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule